// File: doc/BRIEF.md
# Optimal Filter Energy and Time Extractor

This block turns digitized pulse samples into per-channel physics quantities after a trigger. A board's channels arrive one after another as a sample stream. Each channel contributes a window of five consecutive samples. For every window the block removes a per-channel baseline, forms two weighted sums with per-channel coefficients, and produces three results: the deposited energy, the product of energy and arrival time, and a pulse-shape quality figure. The quality figure is the sum of squared differences between the samples and the energy-scaled reference shape.

Coefficients live in a writable per-channel memory. Each channel has sixteen words: a baseline, five energy weights, five time weights and five reference-shape values. An event covers one result for each of NCH windows. Coefficient writes are refused while an event is in flight, so an event is never processed with a half-updated set of constants. The arithmetic accepts one sample per clock with no stall. The division that turns the time term into a time is left to the consumer.

Top module: `ofx_extractor`

## Requirements
- R1: After reset `res_valid` is low and every coefficient word is zero, so that a window processed before any write gives energy 0, time term 0 and quality equal to the sum of the squared raw samples.
- R2: Every fifth accepted sample (a cycle with `smp_valid` high), counted from reset, closes a window, and each window yields exactly one result. Cycles with `smp_valid` low may fall anywhere and are skipped. `res_chan` is the channel index given with the window's fifth sample, and the coefficients used for each sample come from the channel given with that sample.
- R3: With baseline P and samples x0..x4 (unsigned), d_k = x_k - P as a signed value. `res_energy` = floor((sum of a_k * d_k) / 2^FRAC), as a signed EW-bit value.
- R4: `res_time` = floor((sum of b_k * d_k) / 2^FRAC), as a signed EW-bit value. This is energy times time, with no division.
- R5: `res_quality` = sum over k of r_k^2, where r_k = d_k - floor(E * g_k / 2^FRAC) and E is the energy of R3. It is unsigned and QW bits wide.
- R6: A write to channel `cfg_chan` stores `cfg_data` in field `cfg_fld`. Field 0 is the unsigned baseline. Fields 1..5 are a0..a4, fields 6..10 are b0..b4 and fields 11..15 are g0..g4, all signed two's complement.
- R7: Samples are accepted on every clock with no stall. A result appears exactly 4 cycles after the clock edge that takes in the window's fifth sample.
- R8: An event starts with the first accepted sample and ends on the clock edge after the NCH-th result. A write issued while the event is open, including one in the same cycle as the event's first sample, is ignored. A write issued after the event ends takes effect.
- R9: Samples below the baseline give negative differences, which are handled as signed values and floored toward minus infinity. Samples close to full scale give results with no loss of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | SW | Unsigned ADC sample |
| smp_chan | input | CHW | Channel index of the sample |
| cfg_we | input | 1 | Coefficient write request |
| cfg_chan | input | CHW | Channel addressed by the write |
| cfg_fld | input | 4 | Coefficient field, 0..15 |
| cfg_data | input | CW | Coefficient value |
| res_valid | output | 1 | Result present this cycle |
| res_chan | output | CHW | Channel of the result |
| res_energy | output | EW | Signed energy |
| res_time | output | EW | Signed energy-times-time term |
| res_quality | output | QW | Sum of squared residuals |

## Verification
Four events are streamed. The first uses the zeroed memory and a linear ramp, so the quality output must equal the plain sum of squares, which separates baseline and weight handling from the squaring path. The next events use per-channel coefficients and mix three sample patterns. A shaped pulse with small noise, some windows having zero amplitude, gives a small quality value and exposes errors in the residual subtraction. Samples below the baseline expose sign and rounding errors. Near-full-scale samples expose truncated accumulators. One event inserts idle cycles between samples to confirm that windows are counted by accepted samples only. Writes are placed in the middle of an event and on its first sample, and must have no effect on later results. A write placed after the event must change the results of the next event.

// File: rtl/ofx_pkg.sv
// Shared constants for the optimal filter extractor: window length and the
// layout of the sixteen coefficient words kept for each channel.
package ofx_pkg;
    localparam int NSMP    = 5;   // samples per channel window
    localparam int NFLD    = 16;  // coefficient words per channel
    localparam int FLD_PED = 0;   // baseline word
    localparam int FLD_A   = 1;   // first energy weight
    localparam int FLD_B   = 6;   // first time weight
    localparam int FLD_G   = 11;  // first reference-shape value
    localparam int FLDW    = 4;   // field index width
    localparam int IDXW    = 3;   // sample position width
endpackage

// File: rtl/ofx_coef_mem.sv
// Per-channel coefficient store. It has one write port and four combinational
// read ports that return the baseline and the three weights belonging to one
// sample position. Assumes the caller has already gated writes.
module ofx_coef_mem
    import ofx_pkg::*;
#(
    parameter int NCH = 128,
    parameter int CW  = 16,
    parameter int CHW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CHW-1:0]  wr_chan,
    input  logic [FLDW-1:0] wr_fld,
    input  logic [CW-1:0]   wr_data,
    input  logic [CHW-1:0]  rd_chan,
    input  logic [IDXW-1:0] rd_idx,
    output logic [CW-1:0]   rd_ped,
    output logic [CW-1:0]   rd_a,
    output logic [CW-1:0]   rd_b,
    output logic [CW-1:0]   rd_g
);
    logic [CW-1:0] store [NCH][NFLD];

    // Clear every word on reset, then take gated writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                for (int f = 0; f < NFLD; f++) begin
                    store[c][f] <= '0;
                end
            end
        end else if (wr_en) begin
            store[wr_chan][wr_fld] <= wr_data;
        end
    end

    assign rd_ped = store[rd_chan][FLD_PED];
    assign rd_a   = store[rd_chan][FLDW'(FLD_A) + FLDW'(rd_idx)];
    assign rd_b   = store[rd_chan][FLDW'(FLD_B) + FLDW'(rd_idx)];
    assign rd_g   = store[rd_chan][FLDW'(FLD_G) + FLDW'(rd_idx)];
endmodule

// File: rtl/ofx_window.sv
// Front half of the datapath. It counts accepted samples into windows of
// five, subtracts the baseline, and accumulates the energy and time weighted
// sums. At the close of each window it hands over the scaled sums together
// with the five differences and shape values. Assumes all five samples of a
// window come from one channel; the result carries the fifth sample's index.
module ofx_window
    import ofx_pkg::*;
#(
    parameter int SW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12,
    parameter int CHW  = 7,
    localparam int DELW = SW + 1,
    localparam int ACCW = SW + CW + 4,
    localparam int EW   = ACCW - FRAC
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [SW-1:0]          in_data,
    input  logic [CHW-1:0]         in_chan,
    input  logic [CW-1:0]          ped,
    input  logic [CW-1:0]          wa,
    input  logic [CW-1:0]          wb,
    input  logic [CW-1:0]          wg,
    output logic [IDXW-1:0]        rd_idx,
    output logic                   win_valid,
    output logic [CHW-1:0]         win_chan,
    output logic signed [EW-1:0]   win_e,
    output logic signed [EW-1:0]   win_t,
    output logic signed [DELW-1:0] win_d [NSMP],
    output logic signed [CW-1:0]   win_g [NSMP]
);
    logic [IDXW-1:0]        idx;
    logic signed [DELW-1:0] delta;

    logic                   s1_valid;
    logic [IDXW-1:0]        s1_idx;
    logic [CHW-1:0]         s1_chan;
    logic signed [DELW-1:0] s1_d;
    logic signed [CW-1:0]   s1_a;
    logic signed [CW-1:0]   s1_b;
    logic signed [CW-1:0]   s1_g;

    logic signed [ACCW-1:0] acc_e;
    logic signed [ACCW-1:0] acc_t;
    logic signed [ACCW-1:0] prod_e;
    logic signed [ACCW-1:0] prod_t;
    logic signed [ACCW-1:0] acc_e_nxt;
    logic signed [ACCW-1:0] acc_t_nxt;
    logic                   s1_first;
    logic                   s1_last;

    logic signed [DELW-1:0] dbuf [NSMP-1];
    logic signed [CW-1:0]   gbuf [NSMP-1];

    // Position of the next accepted sample inside its window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (in_valid) begin
            idx <= (idx == IDXW'(NSMP - 1)) ? '0 : idx + 1'b1;
        end
    end

    assign rd_idx = idx;
    assign delta  = DELW'({1'b0, in_data}) - DELW'({1'b0, ped});

    // Stage 1: register the difference and the weights for this sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_chan  <= '0;
            s1_d     <= '0;
            s1_a     <= '0;
            s1_b     <= '0;
            s1_g     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_idx  <= idx;
                s1_chan <= in_chan;
                s1_d    <= delta;
                s1_a    <= wa;
                s1_b    <= wb;
                s1_g    <= wg;
            end
        end
    end

    assign s1_first  = (s1_idx == '0);
    assign s1_last   = (s1_idx == IDXW'(NSMP - 1));
    assign prod_e    = ACCW'(s1_a) * ACCW'(s1_d);
    assign prod_t    = ACCW'(s1_b) * ACCW'(s1_d);
    assign acc_e_nxt = (s1_first ? '0 : acc_e) + prod_e;
    assign acc_t_nxt = (s1_first ? '0 : acc_t) + prod_t;

    // Stage 2: accumulate both weighted sums and buffer the window samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_e <= '0;
            acc_t <= '0;
            for (int k = 0; k < NSMP - 1; k++) begin
                dbuf[k] <= '0;
                gbuf[k] <= '0;
            end
        end else if (s1_valid) begin
            acc_e <= acc_e_nxt;
            acc_t <= acc_t_nxt;
            for (int k = 0; k < NSMP - 1; k++) begin
                if (s1_idx == IDXW'(k)) begin
                    dbuf[k] <= s1_d;
                    gbuf[k] <= s1_g;
                end
            end
        end
    end

    // Window hand-over: scale the sums and freeze the five samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_chan  <= '0;
            win_e     <= '0;
            win_t     <= '0;
            for (int k = 0; k < NSMP; k++) begin
                win_d[k] <= '0;
                win_g[k] <= '0;
            end
        end else begin
            win_valid <= s1_valid & s1_last;
            if (s1_valid && s1_last) begin
                win_chan <= s1_chan;
                win_e    <= EW'(acc_e_nxt >>> FRAC);
                win_t    <= EW'(acc_t_nxt >>> FRAC);
                for (int k = 0; k < NSMP - 1; k++) begin
                    win_d[k] <= dbuf[k];
                    win_g[k] <= gbuf[k];
                end
                win_d[NSMP-1] <= s1_d;
                win_g[NSMP-1] <= s1_g;
            end
        end
    end
endmodule

// File: rtl/ofx_quality.sv
// Back half of the datapath. Five parallel lanes subtract the energy-scaled
// reference shape from each difference. The squared residuals are then
// summed into the quality figure, one window per clock at most. Assumes
// win_valid never comes in two cycles back to back.
module ofx_quality
    import ofx_pkg::*;
#(
    parameter int SW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12,
    parameter int CHW  = 7,
    localparam int DELW = SW + 1,
    localparam int EW   = SW + CW + 4 - FRAC,
    localparam int MW   = EW + CW,
    localparam int RW   = EW + CW - FRAC + 1,
    localparam int QW   = 2 * RW + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   win_valid,
    input  logic [CHW-1:0]         win_chan,
    input  logic signed [EW-1:0]   win_e,
    input  logic signed [EW-1:0]   win_t,
    input  logic signed [DELW-1:0] win_d [NSMP],
    input  logic signed [CW-1:0]   win_g [NSMP],
    output logic                   res_valid,
    output logic [CHW-1:0]         res_chan,
    output logic [EW-1:0]          res_energy,
    output logic [EW-1:0]          res_time,
    output logic [QW-1:0]          res_quality
);
    logic signed [RW-1:0] resid [NSMP];
    logic signed [RW-1:0] q1_r  [NSMP];
    logic                 q1_valid;
    logic [CHW-1:0]       q1_chan;
    logic signed [EW-1:0] q1_e;
    logic signed [EW-1:0] q1_t;
    logic signed [QW-1:0] sq_sum;

    for (genvar k = 0; k < NSMP; k++) begin : g_lane
        logic signed [MW-1:0] scaled;
        assign scaled   = MW'(win_e) * MW'(win_g[k]);
        assign resid[k] = RW'(win_d[k]) - RW'(scaled >>> FRAC);
    end

    // Register the residuals alongside the energy and time terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q1_valid <= 1'b0;
            q1_chan  <= '0;
            q1_e     <= '0;
            q1_t     <= '0;
            for (int k = 0; k < NSMP; k++) begin
                q1_r[k] <= '0;
            end
        end else begin
            q1_valid <= win_valid;
            if (win_valid) begin
                q1_chan <= win_chan;
                q1_e    <= win_e;
                q1_t    <= win_t;
                for (int k = 0; k < NSMP; k++) begin
                    q1_r[k] <= resid[k];
                end
            end
        end
    end

    // Sum of the squared residuals.
    always_comb begin
        sq_sum = '0;
        for (int k = 0; k < NSMP; k++) begin
            sq_sum = sq_sum + QW'(q1_r[k]) * QW'(q1_r[k]);
        end
    end

    // Output register for the finished result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_chan    <= '0;
            res_energy  <= '0;
            res_time    <= '0;
            res_quality <= '0;
        end else begin
            res_valid <= q1_valid;
            if (q1_valid) begin
                res_chan    <= q1_chan;
                res_energy  <= q1_e;
                res_time    <= q1_t;
                res_quality <= sq_sum;
            end
        end
    end
endmodule

// File: rtl/ofx_evt_ctrl.sv
// Event tracker. The event opens on any accepted sample and closes after
// NCH results have come out. While it is open, or in the cycle that opens
// it, coefficient writes are refused. Assumes every event carries exactly
// NCH windows.
module ofx_evt_ctrl #(
    parameter int NCH = 128,
    localparam int CNTW = $clog2(NCH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic res_valid,
    input  logic cfg_we,
    output logic wr_ok
);
    logic            busy;
    logic [CNTW-1:0] done_cnt;
    logic            last_res;

    assign last_res = res_valid && (done_cnt == CNTW'(NCH - 1));

    // Count results and hold the event-open flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done_cnt <= '0;
        end else begin
            if (res_valid) begin
                done_cnt <= last_res ? '0 : done_cnt + 1'b1;
            end
            busy <= smp_valid | (busy & ~last_res);
        end
    end

    assign wr_ok = cfg_we & ~busy & ~smp_valid;
endmodule

// File: rtl/ofx_extractor.sv
// Top of the optimal filter extractor. It joins the coefficient store, the
// accumulating front end, the residual back end and the event tracker.
// Assumes samples arrive in complete windows of five per channel and that
// each event has NCH windows.
module ofx_extractor
    import ofx_pkg::*;
#(
    parameter int NCH  = 128,
    parameter int SW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12,
    localparam int CHW  = $clog2(NCH),
    localparam int DELW = SW + 1,
    localparam int EW   = SW + CW + 4 - FRAC,
    localparam int QW   = 2 * (EW + CW - FRAC + 1) + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [SW-1:0]   smp_data,
    input  logic [CHW-1:0]  smp_chan,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_chan,
    input  logic [FLDW-1:0] cfg_fld,
    input  logic [CW-1:0]   cfg_data,
    output logic            res_valid,
    output logic [CHW-1:0]  res_chan,
    output logic [EW-1:0]   res_energy,
    output logic [EW-1:0]   res_time,
    output logic [QW-1:0]   res_quality
);
    logic                   mem_we;
    logic [IDXW-1:0]        rd_idx;
    logic [CW-1:0]          c_ped;
    logic [CW-1:0]          c_a;
    logic [CW-1:0]          c_b;
    logic [CW-1:0]          c_g;
    logic                   win_valid;
    logic [CHW-1:0]         win_chan;
    logic signed [EW-1:0]   win_e;
    logic signed [EW-1:0]   win_t;
    logic signed [DELW-1:0] win_d [NSMP];
    logic signed [CW-1:0]   win_g [NSMP];

    ofx_evt_ctrl #(.NCH(NCH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .res_valid (res_valid),
        .cfg_we    (cfg_we),
        .wr_ok     (mem_we)
    );

    ofx_coef_mem #(.NCH(NCH), .CW(CW), .CHW(CHW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_chan (cfg_chan),
        .wr_fld  (cfg_fld),
        .wr_data (cfg_data),
        .rd_chan (smp_chan),
        .rd_idx  (rd_idx),
        .rd_ped  (c_ped),
        .rd_a    (c_a),
        .rd_b    (c_b),
        .rd_g    (c_g)
    );

    ofx_window #(.SW(SW), .CW(CW), .FRAC(FRAC), .CHW(CHW)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_data   (smp_data),
        .in_chan   (smp_chan),
        .ped       (c_ped),
        .wa        (c_a),
        .wb        (c_b),
        .wg        (c_g),
        .rd_idx    (rd_idx),
        .win_valid (win_valid),
        .win_chan  (win_chan),
        .win_e     (win_e),
        .win_t     (win_t),
        .win_d     (win_d),
        .win_g     (win_g)
    );

    ofx_quality #(.SW(SW), .CW(CW), .FRAC(FRAC), .CHW(CHW)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid   (win_valid),
        .win_chan    (win_chan),
        .win_e       (win_e),
        .win_t       (win_t),
        .win_d       (win_d),
        .win_g       (win_g),
        .res_valid   (res_valid),
        .res_chan    (res_chan),
        .res_energy  (res_energy),
        .res_time    (res_time),
        .res_quality (res_quality)
    );
endmodule

// File: rtl/ofx_extractor_chk.sv
// Property checker for the extractor. It keeps its own count of accepted
// samples and results from the ports and checks window timing, channel
// tagging, result spacing and the write lock-out.
module ofx_extractor_chk #(
    parameter int NCH = 128,
    parameter int CHW = 7,
    localparam int CNTW = $clog2(NCH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           smp_valid,
    input logic [CHW-1:0] smp_chan,
    input logic           res_valid,
    input logic [CHW-1:0] res_chan,
    input logic           cfg_we,
    input logic           mem_we
);
    logic [2:0]      phase;
    logic            fifth;
    logic [2:0]      since_rst;
    logic            warm;
    logic [2:0]      gap;
    logic            ck_open;
    logic [CNTW-1:0] ck_cnt;

    assign fifth = smp_valid && (phase == 3'd4);
    assign warm  = (since_rst == 3'd4);

    // Reference bookkeeping derived only from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= '0;
            since_rst <= '0;
            gap       <= 3'd7;
            ck_open   <= 1'b0;
            ck_cnt    <= '0;
        end else begin
            if (smp_valid) phase <= (phase == 3'd4) ? 3'd0 : phase + 3'd1;
            if (!warm) since_rst <= since_rst + 3'd1;
            gap <= res_valid ? 3'd1 : ((gap == 3'd7) ? gap : gap + 3'd1);
            if (res_valid) begin
                ck_cnt <= (ck_cnt == CNTW'(NCH - 1)) ? '0 : ck_cnt + 1'b1;
            end
            if (smp_valid) ck_open <= 1'b1;
            else if (res_valid && ck_cnt == CNTW'(NCH - 1)) ck_open <= 1'b0;
        end
    end

    // R7
    res_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (res_valid == $past(fifth, 4)));

    // R2
    res_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && res_valid) |-> (res_chan == $past(smp_chan, 4)));

    // R2
    res_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (gap >= 3'd5));

    // R8
    write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_open || smp_valid) |-> !mem_we);

    // R6
    write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cfg_we);
endmodule

bind ofx_extractor ofx_extractor_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_chan  (smp_chan),
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .cfg_we    (cfg_we),
    .mem_we    (mem_we)
);

// File: tb/ofx_extractor_tb.sv
// Scoreboard bench: the driver pushes expected results computed from a
// coefficient model, and the monitor pops and compares them as results appear.
module ofx_extractor_tb;
    localparam int NCH = 128;
    localparam int CHW = 7;
    localparam int EW  = 24;
    localparam int QW  = 61;

    typedef struct {
        int     chan;
        longint e;
        longint t;
        longint q;
        longint cyc;
        string  tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            smp_valid = 1'b0;
    logic [15:0]     smp_data = '0;
    logic [CHW-1:0]  smp_chan = '0;
    logic            cfg_we = 1'b0;
    logic [CHW-1:0]  cfg_chan = '0;
    logic [3:0]      cfg_fld = '0;
    logic [15:0]     cfg_data = '0;
    logic            res_valid;
    logic [CHW-1:0]  res_chan;
    logic [EW-1:0]   res_energy;
    logic [EW-1:0]   res_time;
    logic [QW-1:0]   res_quality;

    int     mdl [NCH][16];
    exp_t   sb [$];
    longint cyc = 0;
    int     vectors = 0;
    int     misses = 0;
    bit     finished = 1'b0;

    ofx_extractor u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_chan(smp_chan), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_fld(cfg_fld), .cfg_data(cfg_data), .res_valid(res_valid),
        .res_chan(res_chan), .res_energy(res_energy), .res_time(res_time),
        .res_quality(res_quality)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t calc(int c, int xs[5], string tag);
        exp_t   r;
        longint d [5];
        longint se = 0, st = 0, q = 0, e;
        for (int k = 0; k < 5; k++) begin
            d[k] = longint'(xs[k]) - longint'(mdl[c][0]);
            se += longint'(mdl[c][1 + k]) * d[k];
            st += longint'(mdl[c][6 + k]) * d[k];
        end
        e = se >>> 12;
        for (int k = 0; k < 5; k++) begin
            longint rr;
            rr = d[k] - ((e * longint'(mdl[c][11 + k])) >>> 12);
            q += rr * rr;
        end
        r.chan = c; r.e = e; r.t = st >>> 12; r.q = q; r.cyc = 0; r.tag = tag;
        return r;
    endfunction

    function automatic int sample(int mode, int c, int k);
        int shp [5] = '{800, 2500, 4096, 2500, 800};
        int ped = mdl[c][0];
        int amp;
        case (mode)
            0: return 500 + 100 * k + 3 * c;
            1: begin
                amp = (c % 4 == 0) ? 0 : 100 * (c % 9 + 1);
                return ped + (amp * shp[k]) / 4096 + ((c * 7 + k * 3) % 11) - 5;
            end
            2: return ped - 30 * (k + 1) - (c % 13);
            default: return 60000 + c * 20 + k * 7;
        endcase
    endfunction

    task automatic cfg_put(int c, int f, int v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_chan = CHW'(c); cfg_fld = 4'(f); cfg_data = v[15:0];
        mdl[c][f] = (f == 0) ? (v & 16'hFFFF) : v;
    endtask

    task automatic load_all();
        int abase [5] = '{-300, 800, 2400, 800, -300};
        int bbase [5] = '{-1500, -900, 0, 900, 1500};
        int gbase [5] = '{800, 2500, 4096, 2500, 800};
        for (int c = 0; c < NCH; c++) begin
            cfg_put(c, 0, 200 + (c * 37) % 400);
            for (int k = 0; k < 5; k++) begin
                cfg_put(c, 1 + k, abase[k] + (c % 5) * 10 * (k - 2));
                cfg_put(c, 6 + k, bbase[k] + c % 7);
                cfg_put(c, 11 + k, gbase[k] - (c % 3) * 50);
            end
        end
        @(posedge clk); #1; cfg_we = 1'b0;
    endtask

    // Stream one event; optionally a write (ignored by R8) at a chosen sample.
    task automatic run_event(int emode, bit gaps, int wch, int wk, string tag);
        int xs [5];
        int m;
        for (int c = 0; c < NCH; c++) begin
            m = (emode < 0) ? ((c + 1) % 4) : ((emode == 9) ? (c % 3 + 1) : emode);
            for (int k = 0; k < 5; k++) begin
                @(posedge clk); #1;
                xs[k] = sample(m, c, k);
                smp_valid = 1'b1; smp_data = xs[k][15:0]; smp_chan = CHW'(c);
                if (c == wch && k == wk) begin
                    cfg_we = 1'b1; cfg_chan = CHW'(5 + 4 * (c == 0 ? 1 : 0));
                    cfg_fld = (c == 0) ? 4'd6 : 4'd1; cfg_data = 16'd30000;
                end else begin
                    cfg_we = 1'b0;
                end
                if (k == 4) begin
                    exp_t ex;
                    ex = calc(c, xs, tag);
                    ex.cyc = cyc + 4;
                    sb.push_back(ex);
                end
                if (gaps && (c % 2 == 1)) begin
                    @(posedge clk); #1;
                    smp_valid = 1'b0; cfg_we = 1'b0;
                end
            end
        end
        @(posedge clk); #1;
        smp_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (sb.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    // Monitor: compare every result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            vectors++;
            if (sb.size() == 0) begin
                misses++;
                $display("FAIL R2 unexpected result ch=%0d act=1 exp=0", res_chan);
            end else begin
                exp_t ex;
                longint ae, at, aq;
                ex = sb.pop_front();
                ae = longint'($signed(res_energy));
                at = longint'($signed(res_time));
                aq = longint'(res_quality);
                if (int'(res_chan) != ex.chan) begin
                    misses++;
                    $display("FAIL R2 chan act=%0d exp=%0d", res_chan, ex.chan);
                end
                if (ae != ex.e) begin
                    misses++;
                    $display("FAIL %s R3 energy ch=%0d act=%0d exp=%0d", ex.tag, ex.chan, ae, ex.e);
                end
                if (at != ex.t) begin
                    misses++;
                    $display("FAIL %s R4 time ch=%0d act=%0d exp=%0d", ex.tag, ex.chan, at, ex.t);
                end
                if (aq != ex.q) begin
                    misses++;
                    $display("FAIL %s R5 quality ch=%0d act=%0d exp=%0d", ex.tag, ex.chan, aq, ex.q);
                end
                vectors++;
                if (cyc != ex.cyc) begin
                    misses++;
                    $display("FAIL R7 latency ch=%0d act=%0d exp=%0d", ex.chan, cyc, ex.cyc);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int f = 0; f < 16; f++) mdl[c][f] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (res_valid !== 1'b0) begin
            misses++;
            $display("FAIL R1 res_valid in reset act=%b exp=0", res_valid);
        end
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (res_valid !== 1'b0) begin
            misses++;
            $display("FAIL R1 res_valid after reset act=%b exp=0", res_valid);
        end
        // R1: zeroed coefficients, ramp samples.
        run_event(0, 1'b0, -1, 0, "R1");
        wait_idle();
        // R6: load coefficients; back-to-back mixed patterns (R7, R9).
        load_all();
        run_event(9, 1'b0, -1, 0, "R6/R9");
        wait_idle();
        // R2 idle gaps; R8 write to channel 5 a0 during the event is ignored.
        run_event(-1, 1'b1, 60, 2, "R2/R8");
        wait_idle();
        // R8: a write after the event takes effect (channel 7 a0).
        cfg_put(7, 1, 1234);
        @(posedge clk); #1; cfg_we = 1'b0;
        // R8: write on the event's first sample (channel 9 b0) is ignored.
        run_event(1, 1'b0, 0, 0, "R8");
        wait_idle();
        finish_run();
    end
endmodule